// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets any of up to four cores raise an interrupt on any other core, find out who raised it, and clear each request. Every core owns a command port carrying a 2-bit opcode and a core-number operand, plus a readback register through which query results come back. Inside, a sender-by-target matrix of pending bits records outstanding requests, and one interrupt line per core is asserted while any sender has a request pending towards that core.

Only one command is accepted per cycle. A fixed-priority arbiter picks the lowest-numbered core that presents a valid command. The command port is valid/ready. A core raises `cmd_valid` and holds its opcode and operand stable until it sees its `cmd_ready` bit high in the same cycle as its valid. `cmd_ready` is a combinational function of the valid bits only and is never high for a core whose valid is low. The interrupt lines and readback registers are plain status outputs with no handshake.

Requests from several senders to one target merge into a single asserted line. The target reads a source mask with one bit per sender and acknowledges each sender in turn. A request repeated while its bit is still set is not queued, so a sender polls status before sending again.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every pending bit is clear, every `irq` bit is 0 and every readback register reads 0.
- R2: In each cycle at most one `cmd_ready` bit is high. It belongs to the lowest-indexed core with `cmd_valid` high, and that command is the one accepted.
- R3: An accepted raise command (opcode 1) from core S with operand T, where T differs from S, sets pending bit [S][T]. `irq[T]` is high from the cycle after acceptance while any bit [*][T] is set.
- R4: A raise command whose operand equals the issuing core changes no pending bit and no `irq` line.
- R5: An accepted status command (opcode 0) from core S with operand T loads readback S with the value 1 (bit 0) if pending bit [S][T] is set, and 0 otherwise, in the cycle after acceptance.
- R6: An accepted source command (opcode 2) from core T loads readback T with a mask whose bit k is pending bit [k][T], in the cycle after acceptance.
- R7: An accepted acknowledge command (opcode 3) from core T with operand c clears pending bit [c][T] only. `irq[T]` falls once no bit [*][T] remains set, and the other `irq` lines are unaffected.
- R8: A second raise from S to T while [S][T] is still set does not queue. A single acknowledge clears it.
- R9: Readback S changes only on an accepted status or source command from core S. Raise and acknowledge commands leave every readback unchanged.
- R10: Raises from several senders to one target merge into one asserted line, and the source mask then shows every one of those senders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N | Per-core command valid |
| cmd_ready | output | N | Per-core command accepted this cycle |
| cmd_op | input | 2*N | Per-core opcode: 0 status, 1 raise, 2 source, 3 acknowledge; core i at bits [2i+1:2i] |
| cmd_arg | input | IW*N | Per-core core-number operand; core i at bits [IW*i+IW-1:IW*i] |
| rdback | output | N*N | Per-core readback register; core i at bits [N*i+N-1:N*i] |
| irq | output | N | Per-core interrupt line |

## Verification
`cmd_ready` answers in the same cycle as the valid bits, so the bench samples it one time step after driving inputs at the falling edge. `irq` and the readback registers change on the rising edge that accepts a command, so the bench checks them at the next falling edge. At that point its behavioural model has already applied the accepted command. The model picks the winner from the driven valids, updates its own pending array and readback values, and every output is compared with it each cycle. Directed sequences cover merged senders, self-raise, repeated raise and readback holding, and a long run of random commands that keep each valid held until it is accepted follows them.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    CMD_PEEK   = 2'd0,
    CMD_RAISE  = 2'd1,
    CMD_SOURCE = 2'd2,
    CMD_ACK    = 2'd3
  } ipi_cmd_e;

  localparam int OP_W = 2;

endpackage

// File: rtl/ipi_cmd_arbiter.sv
module ipi_cmd_arbiter #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);

  // lowest index wins
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
        idx    = IW'(i);
      end
    end
  end

endmodule

// File: rtl/ipi_pending_matrix.sv
module ipi_pending_matrix
  import ipi_pkg::*;
#(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_en,
  input  ipi_cmd_e              cmd,
  input  logic [IW-1:0]         who,
  input  logic [IW-1:0]         arg,
  output logic [N-1:0][N-1:0]   pend,   // pend[sender][target]
  output logic [N-1:0]          line
);

  for (genvar s = 0; s < N; s++) begin : g_src
    for (genvar t = 0; t < N; t++) begin : g_dst
      if (s == t) begin : g_diag
        assign pend[s][t] = 1'b0;
      end else begin : g_cell
        logic bit_q;
        logic set_c;
        logic clr_c;
        assign set_c = cmd_en && (cmd == CMD_RAISE) &&
                       (who == IW'(s)) && (arg == IW'(t));
        assign clr_c = cmd_en && (cmd == CMD_ACK) &&
                       (who == IW'(t)) && (arg == IW'(s));
        always_ff @(posedge clk) begin
          if (!rst_n)     bit_q <= 1'b0;
          else if (set_c) bit_q <= 1'b1;
          else if (clr_c) bit_q <= 1'b0;
        end
        assign pend[s][t] = bit_q;
      end
    end
  end

  for (genvar t = 0; t < N; t++) begin : g_line
    logic [N-1:0] col;
    for (genvar s = 0; s < N; s++) begin : g_col
      assign col[s] = pend[s][t];
    end
    assign line[t] = |col;
  end

endmodule

// File: rtl/ipi_readback_bank.sv
module ipi_readback_bank
  import ipi_pkg::*;
#(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_en,
  input  ipi_cmd_e            cmd,
  input  logic [IW-1:0]       who,
  input  logic [IW-1:0]       arg,
  input  logic [N-1:0][N-1:0] pend,
  output logic [N-1:0][N-1:0] rb
);

  logic [N-1:0] result;
  logic         is_query;

  assign is_query = (cmd == CMD_PEEK) || (cmd == CMD_SOURCE);

  always_comb begin
    result = '0;
    if (cmd == CMD_PEEK) begin
      result[0] = pend[who][arg];
    end else begin
      for (int k = 0; k < N; k++) result[k] = pend[k][who];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [N-1:0] rb_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        rb_q <= '0;
      else if (cmd_en && is_query && (who == IW'(i)))
        rb_q <= result;
    end
    assign rb[i] = rb_q;
  end

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      cmd_valid,
  output logic [N-1:0]      cmd_ready,
  input  logic [OP_W*N-1:0] cmd_op,
  input  logic [IW*N-1:0]   cmd_arg,
  output logic [N*N-1:0]    rdback,
  output logic [N-1:0]      irq
);

  logic [OP_W-1:0] op_arr  [N];
  logic [IW-1:0]   arg_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_split
    assign op_arr[i]  = cmd_op[i*OP_W +: OP_W];
    assign arg_arr[i] = cmd_arg[i*IW +: IW];
  end

  logic          acc;
  logic [IW-1:0] win;
  ipi_cmd_e      sel_cmd;
  logic [IW-1:0] sel_arg;

  ipi_cmd_arbiter #(.N(N)) u_arb (
    .req (cmd_valid),
    .gnt (cmd_ready),
    .any (acc),
    .idx (win)
  );

  assign sel_cmd = ipi_cmd_e'(op_arr[win]);
  assign sel_arg = arg_arr[win];

  logic [N-1:0][N-1:0] pend;
  logic [N-1:0][N-1:0] rb;

  ipi_pending_matrix #(.N(N)) u_mat (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_en (acc),
    .cmd    (sel_cmd),
    .who    (win),
    .arg    (sel_arg),
    .pend   (pend),
    .line   (irq)
  );

  ipi_readback_bank #(.N(N)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_en (acc),
    .cmd    (sel_cmd),
    .who    (win),
    .arg    (sel_arg),
    .pend   (pend),
    .rb     (rb)
  );

  assign rdback = rb;

endmodule

// File: rtl/ipi_mailbox_checker.sv
module ipi_mailbox_checker #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      cmd_valid,
  input logic [N-1:0]      cmd_ready,
  input logic [2*N-1:0]    cmd_op,
  input logic [IW*N-1:0]   cmd_arg,
  input logic [N*N-1:0]    rdback,
  input logic [N-1:0]      irq
);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_ready));

  p_grant_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready & ~cmd_valid) == '0);

  p_head_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid[0] |-> cmd_ready[0]);

  for (genvar s = 0; s < N; s++) begin : g_s
    logic [1:0]    op_s;
    logic [IW-1:0] arg_s;
    assign op_s  = cmd_op[2*s +: 2];
    assign arg_s = cmd_arg[IW*s +: IW];

    p_self_raise_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready[s] && op_s == 2'd1 && arg_s == IW'(s)) |=> $stable(irq));

    p_readback_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ready[s] && op_s[0] == 1'b0) |=> $stable(rdback[N*s +: N]));

    for (genvar t = 0; t < N; t++) begin : g_t
      localparam logic [N-1:0] KEEP = ~({{(N-1){1'b0}}, 1'b1} << t);
      if (s != t) begin : g_pair
        p_raise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (cmd_ready[s] && op_s == 2'd1 && arg_s == IW'(t)) |=> irq[t]);
      end
      if (s == t) begin : g_own
        p_ack_spares_others_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (cmd_ready[s] && op_s == 2'd3) |=> $stable(irq & KEEP));
      end
    end
  end

endmodule

bind ipi_mailbox ipi_mailbox_checker #(.N(N)) u_ipi_chk (.*);

// File: tb/ipi_mailbox_bench.sv
module ipi_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    vld = '0;
  logic [2*N-1:0]  op  = '0;
  logic [IW*N-1:0] arg = '0;
  logic [N-1:0]    rdy;
  logic [N*N-1:0]  rdback;
  logic [N-1:0]    irq;

  int checks = 0;
  int errors = 0;
  int pend [N][N];
  int rbm  [N];
  logic [N-1:0] last_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_mailbox #(.N(N)) u_ipi_mailbox (
    .clk(clk), .rst_n(rst_n), .cmd_valid(vld), .cmd_ready(rdy),
    .cmd_op(op), .cmd_arg(arg), .rdback(rdback), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rb_of(input int c);
    return rdback[c*N +: N];
  endfunction

  // one clock: check ready, let the edge pass, update model, compare outputs
  task automatic cycle();
    int g;
    logic [N-1:0] eg;
    int o, a;
    #1;
    g = -1;
    for (int i = N-1; i >= 0; i--) if (vld[i]) g = i;
    eg = (g < 0) ? '0 : (N'(1) << g);
    last_rdy = rdy;
    chk(rdy == eg, "R2 ready", 32'(rdy), 32'(eg));
    @(posedge clk);
    if (g >= 0) begin
      o = int'(op[g*2 +: 2]);
      a = int'(arg[g*IW +: IW]);
      case (o)
        0: rbm[g] = pend[g][a];
        1: if (a != g) pend[g][a] = 1;
        2: begin
             rbm[g] = 0;
             for (int k = 0; k < N; k++) if (pend[k][g] != 0) rbm[g] += (1 << k);
           end
        default: pend[a][g] = 0;
      endcase
    end
    @(negedge clk);
    for (int t = 0; t < N; t++) begin
      int any = 0;
      for (int s = 0; s < N; s++) if (pend[s][t] != 0) any = 1;
      chk(irq[t] == any[0], "R3/R7 irq", 32'(irq[t]), 32'(any));
    end
    for (int c = 0; c < N; c++)
      chk(rb_of(c) == N'(rbm[c]), "R5/R6/R9 readback", 32'(rb_of(c)), 32'(rbm[c]));
  endtask

  task automatic send(input int c, input int o, input int a);
    vld = '0;
    vld[c] = 1'b1;
    op[c*2 +: 2]   = 2'(o);
    arg[c*IW +: IW] = IW'(a);
    cycle();
    vld = '0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin
      rbm[s] = 0;
      for (int t = 0; t < N; t++) pend[s][t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(irq == '0, "R1 irq after reset", 32'(irq), 0);
    chk(rdback == '0, "R1 readback after reset", 32'(rdback), 0);

    // R3: core1 raises core2
    send(1, 1, 2);
    chk(irq == 4'b0100, "R3 irq of target", 32'(irq), 32'h4);
    // R5: status of 1->2
    send(1, 0, 2);
    chk(rb_of(1) == 4'b0001, "R5 status pending", 32'(rb_of(1)), 1);

    // R2/R10: cores 0 and 3 raise core2 together
    vld = 4'b1001;
    op[0 +: 2] = 2'd1; arg[0 +: IW] = 2'd2;
    op[6 +: 2] = 2'd1; arg[6 +: IW] = 2'd2;
    cycle();
    chk(last_rdy == 4'b0001, "R2 core0 first", 32'(last_rdy), 1);
    vld = 4'b1000;
    cycle();
    chk(last_rdy == 4'b1000, "R2 core3 next", 32'(last_rdy), 8);
    vld = '0;
    send(2, 2, 0);
    chk(rb_of(2) == 4'b1011, "R10 merged source mask", 32'(rb_of(2)), 32'hb);
    chk(irq == 4'b0100, "R10 single line", 32'(irq), 32'h4);

    // R6/R7: acknowledge one source at a time
    send(2, 3, 1);
    chk(irq[2] == 1'b1, "R7 line stays with sources left", 32'(irq[2]), 1);
    send(2, 2, 0);
    chk(rb_of(2) == 4'b1001, "R6 mask after one ack", 32'(rb_of(2)), 9);
    send(2, 3, 0);
    send(2, 3, 3);
    chk(irq == 4'b0000, "R7 line drops after last ack", 32'(irq), 0);

    // R4: self raise
    send(1, 1, 1);
    chk(irq == 4'b0000, "R4 self raise ignored", 32'(irq), 0);

    // R8: repeat raise does not queue
    send(0, 1, 1);
    send(0, 1, 1);
    send(1, 3, 0);
    chk(irq[1] == 1'b0, "R8 repeat not queued", 32'(irq[1]), 0);

    // R9: readback holds across raise and ack
    send(1, 0, 3);
    chk(rb_of(1) == 4'b0000, "R9 status clear", 32'(rb_of(1)), 0);
    send(1, 1, 3);
    chk(rb_of(1) == 4'b0000, "R9 raise leaves readback", 32'(rb_of(1)), 0);
    send(1, 0, 3);
    chk(rb_of(1) == 4'b0001, "R9 status set", 32'(rb_of(1)), 1);
    send(3, 3, 1);
    chk(rb_of(1) == 4'b0001, "R9 ack leaves readback", 32'(rb_of(1)), 1);

    // random commands, valid held until accepted
    vld = '0;
    last_rdy = '0;
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N; i++) begin
        if (!(vld[i] && !last_rdy[i])) begin
          vld[i] = ($urandom % 3) != 0;
          op[i*2 +: 2] = 2'($urandom);
          arg[i*IW +: IW] = IW'($urandom);
        end
      end
      cycle();
    end
    vld = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule